// File: doc/BRIEF.md
# I/O Transfer Pulse Sequencer

This block is the processor-side controller for a 12-bit I/O bus. The decoder presents an I/O transfer instruction together with a one-cycle start strobe. The block latches the instruction and drives its device-select field onto the bus address lines. It then runs a fixed six-cycle sequence in which each of the three function bits can fire its own pulse line, and the three lines fire in a fixed order that never overlaps. A done flag marks the end of the sequence.

The block also holds the accumulator and the program counter. Peripherals reach these only through wired-OR bus lines. A data-in line that is high sets its accumulator bit. The clear line zeroes the whole accumulator, and the clear is applied before the set. A skip pulse advances the program counter by one, so the next instruction is passed over. The accumulator contents always appear on the data-out lines.

Top module: `iot_pulse_seq`

## Requirements
- R1: The instruction word is split into the opcode in bits [11:9], the device address in bits [8:3] and the function field in bits [2:0]. `dev_addr_o` shows the address field of the most recently accepted instruction from the first cycle after the accepting edge, and it holds that value until the next accepted start.
- R2: Pulses appear only when the latched opcode equals binary 110. With any other opcode the sequence still runs, but all pulse lines stay low.
- R3: Function bit 0 drives `iop_o[0]`, bit 1 drives `iop_o[1]` and bit 2 drives `iop_o[2]`. Each pulse lasts exactly one cycle, and a function bit that is zero produces no pulse.
- R4: Counting the cycle after the accepting edge as cycle 1, `iop_o[0]` may be high only in cycle 1, `iop_o[1]` only in cycle 3 and `iop_o[2]` only in cycle 5. At most one line is high at a time, and every pulse is followed by a cycle with all lines low.
- R5: The sequence always lasts six cycles. `done_o` is low during the sequence, is high from cycle 7 until the next accepted start, and is low with all pulse lines low out of reset. A start strobe that arrives while a sequence is running is ignored.
- R6: `ac_o` always shows the accumulator.
- R7: At any time, every `din_i` bit that is 1 sets the matching accumulator bit at the next clock edge. The other bits keep their values.
- R8: When `clr_ac_i` is 1, the accumulator becomes zero at the next edge. If `din_i` bits are high in that same cycle, they are applied after the clear, so the result equals `din_i`.
- R9: If `skip_i` is high in any cycle of a running sequence, `pc_o` increases by exactly 1 for that instruction, however many cycles the skip is held. When no sequence is running, `skip_i` is ignored.
- R10: After reset, `ac_o`, `pc_o`, `dev_addr_o`, `iop_o` and `done_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe for an I/O transfer instruction |
| instr_i | input | 12 | Instruction word |
| din_i | input | 12 | Wired-OR data-in lines; a 1 sets the matching accumulator bit |
| clr_ac_i | input | 1 | Wired-OR line that clears the accumulator |
| skip_i | input | 1 | Wired-OR skip request |
| dev_addr_o | output | 6 | Device address lines |
| ac_o | output | 12 | Accumulator data-out lines |
| iop_o | output | 3 | Pulse lines 1, 2 and 4, in bit order 0, 1, 2 |
| done_o | output | 1 | Sequence complete |
| pc_o | output | 12 | Program counter |

## Verification
Counting from the edge that accepts the start, the address lines are due in cycle 1 and each pulse is due in its own odd cycle (1, 3 or 5). The done flag and any skip increment are due in cycle 7. Accumulator changes are due one edge after the bus lines are driven. The bench drives its inputs on the falling edge and samples at the next falling edge, one registered stage later. It sweeps all 64 opcode and function combinations and compares each cycle's pulse lines with a pattern it computes from the instruction bits.

// File: rtl/iot_pkg.sv
// Shared types for the I/O transfer pulse sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package iot_pkg;
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/iot_instr_reg.sv
// Instruction holding register: captures the instruction word on an
// accepted start and splits it into opcode, device address and function.
// Assumes: load_i is a single-cycle accept from the phase controller.
module iot_instr_reg #(
    parameter int WORD_W = 12,
    parameter int OP_W   = 3,
    parameter int FN_W   = 3,
    localparam int DEV_W = WORD_W - OP_W - FN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] instr_i,
    output logic [OP_W-1:0]   opcode_o,
    output logic [DEV_W-1:0]  dev_o,
    output logic [FN_W-1:0]   fn_o
);
    logic [WORD_W-1:0] ir_q;

    // Capture the instruction word when a sequence is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else if (load_i) begin
            ir_q <= instr_i;
        end
    end

    // Split the held word into its fields.
    always_comb begin
        opcode_o = ir_q[WORD_W-1 -: OP_W];
        dev_o    = ir_q[FN_W +: DEV_W];
        fn_o     = ir_q[FN_W-1:0];
    end
endmodule

// File: rtl/iot_phase_ctl.sv
// Phase controller: accepts a start while idle, then walks through
// 2*FN_W phases (a pulse slot and an idle slot for each function bit)
// and raises a sticky done flag at the end.
// Assumes: starts that arrive while a sequence runs are dropped.
module iot_phase_ctl
    import iot_pkg::*;
#(
    parameter int FN_W   = 3,
    localparam int SEQ_LEN = 2 * FN_W,
    localparam int PH_W    = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    output logic            accept_o,
    output logic            busy_o,
    output logic [PH_W-1:0] phase_o,
    output logic            done_o
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(SEQ_LEN - 1);

    seq_state_e      state_q;
    logic [PH_W-1:0] phase_q;
    logic            done_q;

    // A start is taken only when no sequence is running.
    always_comb begin
        accept_o = start_i && (state_q == SEQ_IDLE);
        busy_o   = (state_q == SEQ_RUN);
        phase_o  = phase_q;
        done_o   = done_q;
    end

    // Advance state, phase counter and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            phase_q <= '0;
            done_q  <= 1'b0;
        end else if (accept_o) begin
            state_q <= SEQ_RUN;
            phase_q <= '0;
            done_q  <= 1'b0;
        end else if (state_q == SEQ_RUN) begin
            if (phase_q == LAST_PH) begin
                state_q <= SEQ_IDLE;
                phase_q <= '0;
                done_q  <= 1'b1;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/iot_pulse_gen.sv
// Pulse decoder: function bit g fires line g during phase 2*g, and only
// when the held opcode is the I/O transfer opcode.
// Assumes: phase and busy come from registers, so the outputs are clean.
module iot_pulse_gen #(
    parameter int            OP_W    = 3,
    parameter int            FN_W    = 3,
    parameter logic [OP_W-1:0] IOT_OP = 3'b110,
    localparam int SEQ_LEN = 2 * FN_W,
    localparam int PH_W    = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
    input  logic            busy_i,
    input  logic [PH_W-1:0] phase_i,
    input  logic [OP_W-1:0] opcode_i,
    input  logic [FN_W-1:0] fn_i,
    output logic [FN_W-1:0] iop_o
);
    logic op_hit;

    // Opcode match enables every slot.
    always_comb op_hit = busy_i && (opcode_i == IOT_OP);

    for (genvar g = 0; g < FN_W; g++) begin : g_slot
        localparam logic [PH_W-1:0] SLOT_PH = PH_W'(2 * g);
        // One slot per function bit, in ascending bit order.
        always_comb iop_o[g] = op_hit && fn_i[g] && (phase_i == SLOT_PH);
    end
endmodule

// File: rtl/iot_acc.sv
// Accumulator with wired-OR bus control: clear first, then OR in data-in.
// Assumes: bus lines are already resolved (wired-OR) outside the block.
module iot_acc #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_i,
    input  logic         clr_i,
    output logic [W-1:0] ac_o
);
    logic [W-1:0] ac_q;
    logic [W-1:0] ac_base;

    // Clear takes priority over the held value; set is applied after it.
    always_comb ac_base = clr_i ? '0 : ac_q;

    // Register the updated accumulator every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_q <= '0;
        end else begin
            ac_q <= ac_base | din_i;
        end
    end

    // Data-out lines mirror the accumulator.
    always_comb ac_o = ac_q;
endmodule

// File: rtl/iot_skip_pc.sv
// Program counter advanced by the skip line at most once per sequence.
// Assumes: accept_i and busy_i are never high together.
module iot_skip_pc #(
    parameter int PC_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept_i,
    input  logic            busy_i,
    input  logic            skip_i,
    output logic [PC_W-1:0] pc_o
);
    logic [PC_W-1:0] pc_q;
    logic            taken_q;

    // Count one skip per instruction; re-arm on each accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            taken_q <= 1'b0;
        end else if (accept_i) begin
            taken_q <= 1'b0;
        end else if (busy_i && skip_i && !taken_q) begin
            pc_q    <= pc_q + 1'b1;
            taken_q <= 1'b1;
        end
    end

    // Expose the counter.
    always_comb pc_o = pc_q;
endmodule

// File: rtl/iot_pulse_seq.sv
// Top level of the I/O transfer pulse sequencer: latches an instruction,
// drives its device address, sequences the function pulses, and owns the
// accumulator and program counter that bus lines modify.
// Assumes: instruction fetch and other opcodes are handled elsewhere.
module iot_pulse_seq #(
    parameter int              WORD_W     = 12,
    parameter int              OP_W       = 3,
    parameter int              FN_W       = 3,
    parameter logic [OP_W-1:0] IOT_OPCODE = 3'b110,
    parameter int              PC_W       = 12,
    localparam int DEV_W   = WORD_W - OP_W - FN_W,
    localparam int SEQ_LEN = 2 * FN_W,
    localparam int PH_W    = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] instr_i,
    input  logic [WORD_W-1:0] din_i,
    input  logic              clr_ac_i,
    input  logic              skip_i,
    output logic [DEV_W-1:0]  dev_addr_o,
    output logic [WORD_W-1:0] ac_o,
    output logic [FN_W-1:0]   iop_o,
    output logic              done_o,
    output logic [PC_W-1:0]   pc_o
);
    logic            accept;
    logic            busy;
    logic [PH_W-1:0] phase;
    logic [OP_W-1:0] opcode;
    logic [FN_W-1:0] fn;

    iot_phase_ctl #(.FN_W(FN_W)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .busy_o   (busy),
        .phase_o  (phase),
        .done_o   (done_o)
    );

    iot_instr_reg #(.WORD_W(WORD_W), .OP_W(OP_W), .FN_W(FN_W)) u_ir (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .instr_i  (instr_i),
        .opcode_o (opcode),
        .dev_o    (dev_addr_o),
        .fn_o     (fn)
    );

    iot_pulse_gen #(.OP_W(OP_W), .FN_W(FN_W), .IOT_OP(IOT_OPCODE)) u_pulse (
        .busy_i   (busy),
        .phase_i  (phase),
        .opcode_i (opcode),
        .fn_i     (fn),
        .iop_o    (iop_o)
    );

    iot_acc #(.W(WORD_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .din_i (din_i),
        .clr_i (clr_ac_i),
        .ac_o  (ac_o)
    );

    iot_skip_pc #(.PC_W(PC_W)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .busy_i   (busy),
        .skip_i   (skip_i),
        .pc_o     (pc_o)
    );
endmodule

// File: rtl/iot_pulse_seq_chk.sv
// Checker for the pulse sequencer, bound to the top module ports.
// Assumes: synchronous active-low reset disables every property.
module iot_pulse_seq_chk #(
    parameter int W     = 12,
    parameter int DEV_W = 6,
    parameter int FN_W  = 3,
    parameter int PC_W  = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [W-1:0]     din_i,
    input logic             clr_ac_i,
    input logic [DEV_W-1:0] dev_addr_o,
    input logic [W-1:0]     ac_o,
    input logic [FN_W-1:0]  iop_o,
    input logic             done_o,
    input logic [PC_W-1:0]  pc_o
);
    // R1
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(dev_addr_o));

    // R4
    pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(iop_o));

    // R4
    pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iop_o != '0) |=> (iop_o == '0));

    // R5
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (iop_o == '0));

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R7
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ac_o & $past(din_i)) == $past(din_i)));

    // R8
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ac_i && din_i == '0) |=> (ac_o == '0));

    // R9
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc_o) |-> (pc_o == PC_W'($past(pc_o) + 1'b1)));
endmodule

bind iot_pulse_seq iot_pulse_seq_chk #(
    .W(WORD_W), .DEV_W(DEV_W), .FN_W(FN_W), .PC_W(PC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .din_i      (din_i),
    .clr_ac_i   (clr_ac_i),
    .dev_addr_o (dev_addr_o),
    .ac_o       (ac_o),
    .iop_o      (iop_o),
    .done_o     (done_o),
    .pc_o       (pc_o)
);

// File: tb/iot_pulse_seq_tb.sv
`timescale 1ns/1ps
// Bench: sweeps every opcode/function pair, varied skip patterns and
// accumulator bus operations; expected values computed from the spec.
module iot_pulse_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [11:0] instr_i = '0;
    logic [11:0] din_i = '0;
    logic        clr_ac_i = 1'b0;
    logic        skip_i = 1'b0;
    logic [5:0]  dev_addr_o;
    logic [11:0] ac_o;
    logic [2:0]  iop_o;
    logic        done_o;
    logic [11:0] pc_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    iot_pulse_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .din_i(din_i), .clr_ac_i(clr_ac_i), .skip_i(skip_i),
        .dev_addr_o(dev_addr_o), .ac_o(ac_o), .iop_o(iop_o),
        .done_o(done_o), .pc_o(pc_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Run one instruction; called and returns at a falling edge.
    task automatic run_seq(input logic [11:0] ins, input logic [5:0] skpat, input bit poke);
        logic [11:0] pc0;
        logic [2:0]  exp;
        pc0 = pc_o;
        start_i = 1'b1;
        instr_i = ins;
        @(negedge clk);
        start_i = 1'b0;
        instr_i = ~ins;
        for (int k = 0; k < 6; k++) begin
            exp = '0;
            if ((k % 2 == 0) && ins[11:9] == 3'b110 && ins[k/2])
                exp[k/2] = 1'b1;
            chk("R2 R3 R4 pulse lines", 32'(iop_o), 32'(exp));
            chk("R1 address lines", 32'(dev_addr_o), 32'(ins[8:3]));
            chk("R5 done low while running", 32'(done_o), 0);
            skip_i = skpat[k];
            start_i = poke && (k == 2);
            @(negedge clk);
        end
        skip_i = 1'b0;
        start_i = 1'b0;
        chk("R5 done after six cycles", 32'(done_o), 1);
        chk("R9 one skip per instruction", 32'(pc_o), 32'(pc0 + 12'(skpat != '0)));
        chk("R5 pulses quiet when done", 32'(iop_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        logic [11:0] ins;
        logic [11:0] pc_keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset values
        chk("R10 ac reset", 32'(ac_o), 0);
        chk("R10 pc reset", 32'(pc_o), 0);
        chk("R10 addr reset", 32'(dev_addr_o), 0);
        chk("R10 pulses reset", 32'(iop_o), 0);
        chk("R10 done reset", 32'(done_o), 0);

        // R6 R7: set bits, OR onto existing content
        din_i = 12'h0A5; @(negedge clk);
        chk("R7 set from zero", 32'(ac_o), 32'h0A5);
        din_i = 12'h300; @(negedge clk);
        chk("R7 OR onto held bits", 32'(ac_o), 32'h3A5);
        din_i = 12'h000; @(negedge clk);
        chk("R6 hold with no bus input", 32'(ac_o), 32'h3A5);
        // R8: clear alone, then clear with set in the same cycle
        clr_ac_i = 1'b1; @(negedge clk);
        chk("R8 clear", 32'(ac_o), 0);
        din_i = 12'hFFF; clr_ac_i = 1'b0; @(negedge clk);
        chk("R7 set all", 32'(ac_o), 32'hFFF);
        din_i = 12'h041; clr_ac_i = 1'b1; @(negedge clk);
        chk("R8 clear then set", 32'(ac_o), 32'h041);
        din_i = 12'h000; clr_ac_i = 1'b0;

        // R9: skip while idle is ignored
        pc_keep = pc_o;
        skip_i = 1'b1;
        repeat (3) @(negedge clk);
        skip_i = 1'b0;
        @(negedge clk);
        chk("R9 idle skip ignored", 32'(pc_o), 32'(pc_keep));

        // R1-style sweep: every opcode and function pair
        for (int op = 0; op < 8; op++) begin
            for (int fn = 0; fn < 8; fn++) begin
                ins = {3'(op), 6'((op * 8 + fn) ^ 21), 3'(fn)};
                run_seq(ins, 6'((op * 11 + fn * 5) & 63), 1'b0);
                chk("R6 ac untouched by sequencing", 32'(ac_o), 32'h041);
            end
        end

        // R5: start during a running sequence is ignored
        run_seq(12'b110_101010_111, 6'b000100, 1'b1);
        chk("R1 R5 address after ignored start", 32'(dev_addr_o), 32'b101010);
        // R9: skip held through every slot counts once; last slot counts
        run_seq(12'b110_000011_001, 6'b111111, 1'b0);
        run_seq(12'b110_000011_100, 6'b100000, 1'b0);
        // R5: done stays high while idle
        repeat (4) @(negedge clk);
        chk("R5 done held while idle", 32'(done_o), 1);
        summary();
    end
endmodule